// File: doc/BRIEF.md
# PME Wake Request Aggregator

This block merges power-management wake requests from a set of downstream link ports into one wake indication for the upstream hub. Each port delivers a one-cycle receive pulse when a wake message arrives from its link. The pulse counts only while that port's link flag reports the link as up. An accepted pulse sets that port's sticky status bit. The OR of all status bits is the aggregate wake request.

The aggregate request drives a two-message upstream protocol. When the aggregate request goes from idle to active, one assert message is queued. When software has cleared every status bit, one deassert message is queued. Further ports that raise requests while the request is already active only set their own status bits. Messages wait in a small ordered queue behind a valid/ready handshake. If the queue fills, the block holds back the next message until space frees. Messages therefore always alternate and always end on the current aggregate state.

Software reads the status vector directly. It clears bits by presenting a mask with a clear strobe. Each 1 in the mask clears the matching bit.

Top module: `pme_wake_agg`

## Requirements
- R1: A pulse on `pme_rx[i]` sampled while `link_up[i]` is 1 sets `status_o[i]`, visible after that clock edge.
- R2: A pulse on `pme_rx[i]` while `link_up[i]` is 0 is ignored, so `status_o[i]` stays 0.
- R3: Status bits are sticky. Bit i clears only on a cycle with `clr_valid`=1 and `clr_mask[i]`=1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R4: `wake_o` equals the OR of all status bits.
- R5: One edge after the aggregate request becomes 1, an assert message (`msg_code`=2'b01) is presented with `msg_valid`=1.
- R6: While the aggregate request stays 1, newly set ports queue no further message.
- R7: One edge after all status bits become 0, a deassert message (`msg_code`=2'b10) is queued.
- R8: While `msg_valid`=1 and `msg_ready`=0, `msg_valid` stays 1 and `msg_code` stays unchanged.
- R9: Messages leave in the order they were generated and strictly alternate between assert and deassert. If the queue is full, the next message is held back rather than lost, and the stream ends on the current aggregate state.
- R10: While `rst` is 1 and after it, all status bits are 0 and `msg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pme_rx | input | NUM_PORTS | Per-port wake message receive pulse |
| link_up | input | NUM_PORTS | Per-port link communicative flag |
| clr_valid | input | 1 | Status clear strobe |
| clr_mask | input | NUM_PORTS | Write-1-to-clear mask for status |
| status_o | output | NUM_PORTS | Sticky per-port wake status |
| wake_o | output | 1 | Aggregate wake request |
| msg_valid | output | 1 | Upstream message valid |
| msg_code | output | 2 | Message code: 01 assert, 10 deassert |
| msg_ready | input | 1 | Upstream accepts message |

## Verification
Suppose a status bit is stuck or the link gate is broken. The error shows on `status_o` one edge after the stimulus. It also changes the message stream on the next edge. A wrong announced-state register or a wrong queue pointer shows up as a duplicate, missing or reordered code. That error appears only when the queue is drained. So the bench fills the queue with `msg_ready` held low and then compares the full drained sequence.

// File: rtl/pme_agg_pkg.sv
package pme_agg_pkg;
  typedef enum logic [1:0] {
    MSG_NONE     = 2'b00,
    MSG_ASSERT   = 2'b01,
    MSG_DEASSERT = 2'b10
  } msg_code_e;
endpackage

// File: rtl/pme_port_status.sv
module pme_port_status #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pme_rx,
  input  logic [NUM_PORTS-1:0] link_up,
  input  logic                 clr_valid,
  input  logic [NUM_PORTS-1:0] clr_mask,
  output logic [NUM_PORTS-1:0] status_q
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic set_i, clr_i;
    assign set_i = pme_rx[i] & link_up[i];
    assign clr_i = clr_valid & clr_mask[i];

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else if (set_i) status_q[i] <= 1'b1;
      else if (clr_i) status_q[i] <= 1'b0;
    end

    // R2
    link_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!link_up[i] && pme_rx[i] && !status_q[i]) |=> !status_q[i]);

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !(clr_valid && clr_mask[i])) |=> status_q[i]);
  end
endmodule

// File: rtl/pme_msg_sequencer.sv
module pme_msg_sequencer
  import pme_agg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      agg_req,
  input  logic      q_full,
  output logic      push,
  output msg_code_e push_code
);
  logic announced_q;

  assign push      = (agg_req != announced_q) && !q_full;
  assign push_code = agg_req ? MSG_ASSERT : MSG_DEASSERT;

  always_ff @(posedge clk) begin
    if (rst) announced_q <= 1'b0;
    else if (push) announced_q <= agg_req;
  end

  // R9
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (push && push_code == MSG_ASSERT) |=> !(push && push_code == MSG_ASSERT));
endmodule

// File: rtl/pme_msg_queue.sv
module pme_msg_queue
  import pme_agg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  msg_code_e wr_code,
  output logic      full,
  output logic      out_valid,
  output msg_code_e out_code,
  input  logic      out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          rd_en, wr_ok;

  assign full      = (count == (AW+1)'(DEPTH));
  assign out_valid = (count != '0);
  assign rd_en     = out_valid & out_ready;
  assign wr_ok     = wr_en & !full;
  assign out_code  = msg_code_e'(mem[rd_ptr]);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (AW+1)'(wr_ok) - (AW+1)'(rd_en);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
endmodule

// File: rtl/pme_wake_agg.sv
module pme_wake_agg
  import pme_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int MSG_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pme_rx,
  input  logic [NUM_PORTS-1:0] link_up,
  input  logic                 clr_valid,
  input  logic [NUM_PORTS-1:0] clr_mask,
  output logic [NUM_PORTS-1:0] status_o,
  output logic                 wake_o,
  output logic                 msg_valid,
  output logic [1:0]           msg_code,
  input  logic                 msg_ready
);
  logic      push, q_full;
  msg_code_e push_code, head_code;

  pme_port_status #(.NUM_PORTS(NUM_PORTS)) u_status (
    .clk(clk), .rst(rst), .pme_rx(pme_rx), .link_up(link_up),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .status_q(status_o)
  );

  assign wake_o = |status_o;

  pme_msg_sequencer u_seq (
    .clk(clk), .rst(rst), .agg_req(wake_o), .q_full(q_full),
    .push(push), .push_code(push_code)
  );

  pme_msg_queue #(.DEPTH(MSG_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .wr_en(push), .wr_code(push_code),
    .full(q_full), .out_valid(msg_valid), .out_code(head_code),
    .out_ready(msg_ready)
  );

  assign msg_code = head_code;

  // R5
  assert_follows_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake_o) && !q_full) |=> msg_valid);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!msg_valid && status_o == '0));
endmodule

// File: tb/pme_wake_agg_tb.sv
module pme_wake_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst;
  logic [NP-1:0] pme_rx, link_up, clr_mask, status_o;
  logic clr_valid, wake_o, msg_valid, msg_ready;
  logic [1:0] msg_code;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_wake_agg #(.NUM_PORTS(NP), .MSG_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .pme_rx(pme_rx), .link_up(link_up),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .status_o(status_o),
    .wake_o(wake_o), .msg_valid(msg_valid), .msg_code(msg_code),
    .msg_ready(msg_ready)
  );

  // pulse, link, clr, rdy | exp status, exp valid, exp code
  localparam logic [19:0] VEC [16] = '{
    {4'b0001, 4'b1111, 4'b0000, 1'b0, 4'b0001, 1'b0, 2'b00}, // R1
    {4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0001, 1'b1, 2'b01}, // R5
    {4'b0100, 4'b1111, 4'b0000, 1'b0, 4'b0101, 1'b1, 2'b01}, // R6
    {4'b1000, 4'b0111, 4'b0000, 1'b0, 4'b0101, 1'b1, 2'b01}, // R2
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 4'b0101, 1'b0, 2'b00}, // R6
    {4'b0000, 4'b1111, 4'b0001, 1'b0, 4'b0100, 1'b0, 2'b00}, // R3
    {4'b0000, 4'b1111, 4'b0100, 1'b0, 4'b0000, 1'b0, 2'b00}, // R3
    {4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0000, 1'b1, 2'b10}, // R7
    {4'b0010, 4'b1111, 4'b0000, 1'b0, 4'b0010, 1'b1, 2'b10}, // R8
    {4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0010, 1'b1, 2'b10}, // R8
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 4'b0010, 1'b1, 2'b01}, // R9
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 4'b0010, 1'b0, 2'b00}, // R9
    {4'b0010, 4'b1111, 4'b0010, 1'b0, 4'b0010, 1'b0, 2'b00}, // R3
    {4'b0000, 4'b1111, 4'b0010, 1'b0, 4'b0000, 1'b0, 2'b00}, // R3
    {4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0000, 1'b1, 2'b10}, // R7
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 4'b0000, 1'b0, 2'b00}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pme_rx = '0; clr_valid = 1'b0; clr_mask = '0; msg_ready = 1'b0; link_up = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] got [8];
    int n;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 status", 32'(status_o), 32'h0);
    check("R10 valid", 32'(msg_valid), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      pme_rx    = VEC[i][19:16];
      link_up   = VEC[i][15:12];
      clr_mask  = VEC[i][11:8];
      clr_valid = |VEC[i][11:8];
      msg_ready = VEC[i][7];
      @(negedge clk);
      check($sformatf("R1/R3 status v%0d", i), 32'(status_o), 32'(VEC[i][6:3]));
      check($sformatf("R4 wake v%0d", i), 32'(wake_o), 32'(|VEC[i][6:3]));
      check($sformatf("R5/R7 valid v%0d", i), 32'(msg_valid), 32'(VEC[i][2]));
      if (VEC[i][2]) check($sformatf("R8/R9 code v%0d", i), 32'(msg_code), 32'(VEC[i][1:0]));
    end

    // R9: fill the queue with ready low, then drain
    idle();
    for (int k = 0; k < 5; k++) begin
      if (k % 2 == 0) pme_rx = 4'b0001;
      else begin clr_valid = 1'b1; clr_mask = 4'b0001; end
      @(negedge clk);
      idle();
    end
    repeat (3) @(negedge clk);
    check("R8 held valid", 32'(msg_valid), 32'h1);
    check("R8 held code", 32'(msg_code), 32'h1);
    n = 0;
    msg_ready = 1'b1;
    for (int c = 0; c < 12; c++) begin
      if (msg_valid && n < 8) begin got[n] = msg_code; n++; end
      @(negedge clk);
    end
    check("R9 count", 32'(n), 32'd5);
    for (int j = 0; j < 5; j++)
      check($sformatf("R9 order %0d", j), 32'(got[j]), (j % 2 == 0) ? 32'h1 : 32'h2);

    // R10: reset during activity
    idle();
    pme_rx = 4'b1010;
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset status", 32'(status_o), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset valid", 32'(msg_valid), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule